// File: doc/BRIEF.md
# Display-File Fetch and NOP Injector

This block turns a Z80-class CPU into the address generator for character-mapped video. Display-file bytes sit in the upper half of memory. The CPU jumps into them and fetches them as opcodes. On such a fetch the block captures the byte from the single CPU-side data bus. It then forces the data lines to zero so that the CPU executes a NOP instead of the byte. In the refresh half of the same machine cycle it presents a pattern-memory address. That address is built from the upper address lines, which carry the I register, from the captured six-bit code and from a three-bit line row.

Every decision is timed in the pixel-clock domain. The CPU clock passes through a short shift register, and its rising and falling transitions are taken at one tap. This tap fixes the instant inside the T-state where data is captured and where forcing starts. Bit 6 of the captured byte goes back into the forcing decision within the same fetch. A byte with bit 6 set, such as HALT, therefore runs normally. The row counter advances on line sync and is cleared by frame sync.

The style favours valid/ready streams, but nothing here can apply back-pressure: the CPU cycle cannot be stalled. Every port is therefore a plain level or a one-clock strobe. `pat_addr` is meaningful only while `pat_addr_en` is high. `pat_load` is a one-pixel-clock pulse that the serializer must take when it appears.

Top module: `vidfetch_nop`

## Requirements
- R1: While rst_n is low and after its release, before any CPU activity: nop_force, pat_addr_en and pat_load are 0, char_code is 0, invert is 0 and line_row is 0.
- R2: On the CPU-clock rising edge that follows the start of an opcode fetch (m1_n and mreq_n low, addr[15] high), char_code takes data_in[5:0] and invert takes data_in[7]. Bus changes later in the same fetch do not alter them.
- R3: If a captured byte has data_in[6] = 0, nop_force rises after the next CPU-clock falling edge. It stays high until m1_n goes high and is low one pixel clock after that.
- R4: A captured byte with data_in[6] = 1 never raises nop_force, pat_addr_en or pat_load.
- R5: An opcode fetch with addr[15] low changes neither char_code nor invert, and raises no nop_force.
- R6: A memory read with m1_n high changes neither char_code nor invert, and raises no nop_force.
- R7: After a forced fetch, while rfsh_n and mreq_n are both low, pat_addr_en is 1 and pat_addr equals {addr[15:9], char_code, line_row}.
- R8: When rfsh_n returns high after a forced fetch, pat_load is high for exactly one pixel clock, with invert holding the captured bit 7.
- R9: Each rising edge of hsync advances line_row by one, wrapping from 7 to 0.
- R10: While vsync is high, line_row is cleared, and this wins over a simultaneous hsync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk | input | 1 | CPU clock level, sampled by the tap shift register |
| m1_n | input | 1 | CPU opcode-fetch indicator, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh indicator, active low |
| addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU-side data bus as read by the block |
| hsync | input | 1 | Line sync; rising edge advances the row |
| vsync | input | 1 | Frame sync level; clears the row |
| nop_force | output | 1 | Enable for pulling the CPU data lines to zero |
| char_code | output | 6 | Latched character code |
| invert | output | 1 | Latched bit 7, video inversion flag |
| pat_addr | output | 16 | Pattern memory address |
| pat_addr_en | output | 1 | Pattern address valid (refresh after forced fetch) |
| pat_load | output | 1 | One-clock strobe for the serializer to load pattern data |
| line_row | output | 3 | Current character row |

## Verification
Two pairs of functions can land in one pixel clock. The first is a row advance and a frame clear. The bench raises hsync and vsync on the same edge and expects the row to read zero, then confirms a later lone hsync steps it to one. The second is a fresh capture of bit 6 and the forcing decision that depends on it. The sweep over all 256 byte values puts capture and the falling-edge decision in the same fetch. Each fetch is judged by whether nop_force, pat_addr_en and pat_load follow the just-captured bit rather than the one from the previous byte.

// File: rtl/vfn_pkg.sv
package vfn_pkg;
  localparam int CODE_BITS = 6;
  localparam int ROW_BITS  = 3;

  typedef struct packed {
    logic [CODE_BITS-1:0] code;
    logic                 inv;
    logic                 exec;  // bit 6: byte must run, no forcing
  } char_cap_t;
endpackage

// File: rtl/vfn_clk_taps.sv
module vfn_clk_taps #(
  parameter int STROBE_TAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_clk,
  output logic rise,
  output logic fall
);
  localparam int SR_LEN = STROBE_TAP + 2;

  logic [SR_LEN-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[SR_LEN-2:0], cpu_clk};
  end

  // transitions taken between two adjacent taps
  assign rise = hist[STROBE_TAP] & ~hist[STROBE_TAP+1];
  assign fall = ~hist[STROBE_TAP] & hist[STROBE_TAP+1];
endmodule

// File: rtl/vfn_row_ctr.sv
module vfn_row_ctr
  import vfn_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsync,
  input  logic                vsync,
  output logic [ROW_BITS-1:0] row
);
  logic hs_q;
  logic hs_edge;

  assign hs_edge = hsync & ~hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      row  <= '0;
    end else begin
      hs_q <= hsync;
      if (vsync)        row <= '0;
      else if (hs_edge) row <= row + 1'b1;
    end
  end

  assert_frame_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (row == '0));

  assert_row_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge && !vsync) |=> (row == ROW_BITS'($past(row) + 1'b1)));
endmodule

// File: rtl/vfn_fetch_ctrl.sv
module vfn_fetch_ctrl
  import vfn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      fall,
  input  logic      m1_n,
  input  logic      mreq_n,
  input  logic      rfsh_n,
  input  logic      video_sel,
  input  logic [7:0] data_in,
  output char_cap_t cap,
  output logic      nop_force,
  output logic      refresh_en,
  output logic      pat_load
);
  logic cap_done;
  logic is_video;
  logic pend;
  logic rfsh_q;
  logic rfsh_end;

  assign rfsh_end   = pend & rfsh_n & ~rfsh_q;
  assign refresh_en = pend & ~rfsh_n & ~mreq_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap       <= '0;
      cap_done  <= 1'b0;
      is_video  <= 1'b0;
      nop_force <= 1'b0;
      pend      <= 1'b0;
      rfsh_q    <= 1'b1;
      pat_load  <= 1'b0;
    end else begin
      rfsh_q   <= rfsh_n;
      pat_load <= rfsh_end;
      if (rfsh_end) pend <= 1'b0;
      if (m1_n) begin
        cap_done  <= 1'b0;
        nop_force <= 1'b0;
      end else begin
        // T2 rising: capture all kept bits together
        if (rise && !cap_done && !mreq_n) begin
          cap_done <= 1'b1;
          is_video <= video_sel;
          if (video_sel) cap <= '{code: data_in[5:0], inv: data_in[7], exec: data_in[6]};
        end
        // T2 falling: decision uses the bit 6 just captured
        if (fall && cap_done && is_video && !cap.exec) begin
          nop_force <= 1'b1;
          pend      <= 1'b1;
        end
      end
    end
  end

  assert_force_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nop_force |-> $past(!m1_n));

  assert_exec_not_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nop_force |-> !cap.exec);

  assert_capture_in_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap) |-> $past(!m1_n));

  assert_refresh_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |-> !nop_force);

  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_load |=> !pat_load);
endmodule

// File: rtl/vidfetch_nop.sv
module vidfetch_nop
  import vfn_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int STROBE_TAP = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_clk,
  input  logic                 m1_n,
  input  logic                 mreq_n,
  input  logic                 rfsh_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           data_in,
  input  logic                 hsync,
  input  logic                 vsync,
  output logic                 nop_force,
  output logic [CODE_BITS-1:0] char_code,
  output logic                 invert,
  output logic [ADDR_W-1:0]    pat_addr,
  output logic                 pat_addr_en,
  output logic                 pat_load,
  output logic [ROW_BITS-1:0]  line_row
);
  localparam int HI_W  = ADDR_W - CODE_BITS - ROW_BITS;
  localparam int LOW_W = ADDR_W - HI_W;

  logic      rise, fall;
  char_cap_t cap;
  logic      unused_addr;

  assign unused_addr = ^addr[LOW_W-1:0];

  vfn_clk_taps #(.STROBE_TAP(STROBE_TAP)) u_taps (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .rise(rise), .fall(fall)
  );

  vfn_fetch_ctrl u_fetch (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .m1_n(m1_n), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
    .video_sel(addr[ADDR_W-1]), .data_in(data_in),
    .cap(cap), .nop_force(nop_force), .refresh_en(pat_addr_en), .pat_load(pat_load)
  );

  vfn_row_ctr u_row (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .row(line_row)
  );

  assign char_code = cap.code;
  assign invert    = cap.inv;
  assign pat_addr  = {addr[ADDR_W-1 -: HI_W], cap.code, line_row};
endmodule

// File: tb/vidfetch_nop_test.sv
`timescale 1ns/1ps
module vidfetch_nop_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_clk = 1'b0, m1_n = 1'b1, mreq_n = 1'b1, rfsh_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic nop_force, invert, pat_addr_en, pat_load;
  logic [5:0] char_code;
  logic [15:0] pat_addr;
  logic [2:0] line_row;

  int checks = 0, failures = 0, cycles = 0;
  logic [5:0] exp_code = '0;
  logic       exp_inv = 1'b0;
  logic [2:0] exp_row = '0;

  always #10 clk = ~clk;

  vidfetch_nop uut (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .m1_n(m1_n), .mreq_n(mreq_n),
    .rfsh_n(rfsh_n), .addr(addr), .data_in(data_in), .hsync(hsync), .vsync(vsync),
    .nop_force(nop_force), .char_code(char_code), .invert(invert),
    .pat_addr(pat_addr), .pat_addr_en(pat_addr_en), .pat_load(pat_load),
    .line_row(line_row)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hpulse();
    hsync = 1'b1; idle(1); hsync = 1'b0; idle(1);
    exp_row = exp_row + 1'b1;
  endtask

  task automatic run_fetch(input logic [15:0] fa, input logic [7:0] d,
                           input logic is_m1, input logic [15:0] ra);
    logic cap_ok = is_m1 && fa[15];
    logic fz     = cap_ok && !d[6];
    if (cap_ok) begin exp_code = d[5:0]; exp_inv = d[7]; end
    // T1
    cpu_clk = 1'b1; idle(4);
    cpu_clk = 1'b0; m1_n = !is_m1; mreq_n = 1'b0; addr = fa; data_in = d; idle(4);
    // T2 rising: capture
    cpu_clk = 1'b1; idle(4);
    check(cap_ok ? "R2 code" : (is_m1 ? "R5 code" : "R6 code"), char_code, exp_code);
    check(cap_ok ? "R2 inv" : (is_m1 ? "R5 inv" : "R6 inv"), invert, exp_inv);
    // T2 falling: forcing decision from the fresh bit 6
    cpu_clk = 1'b0; idle(4);
    check(fz ? "R3 force" : (cap_ok ? "R4 force" : "R5/R6 force"), nop_force, fz);
    data_in = ~d;
    // T3: fetch ends
    cpu_clk = 1'b1; m1_n = 1'b1; mreq_n = 1'b1; idle(1);
    check("R3 release", nop_force, 1'b0);
    idle(3);
    check("R2 hold code", char_code, exp_code);
    cpu_clk = 1'b0; rfsh_n = 1'b0; mreq_n = 1'b0; addr = ra; idle(4);
    check(fz ? "R7 en" : "R4 en", pat_addr_en, fz);
    if (fz) check("R7 addr", pat_addr, {ra[15:9], exp_code, exp_row});
    // T4
    cpu_clk = 1'b1; idle(4);
    cpu_clk = 1'b0; mreq_n = 1'b1; idle(4);
    rfsh_n = 1'b1; idle(1);
    check(fz ? "R8 load" : "R4 load", pat_load, fz);
    if (fz) check("R8 inv", invert, exp_inv);
    idle(1);
    check("R8 one clock", pat_load, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 force", nop_force, 1'b0);
    check("R1 row", line_row, 3'd0);
    rst_n = 1'b1; idle(2);
    check("R1 code", char_code, 6'd0);
    check("R1 inv", invert, 1'b0);
    check("R1 en", pat_addr_en, 1'b0);
    check("R1 load", pat_load, 1'b0);

    // R2/R3/R4/R7/R8: sweep every byte value as a display-file fetch
    for (int v = 0; v < 256; v++) begin
      if (v % 37 == 36) hpulse();
      run_fetch(16'h8000 | 16'(v * 97 % 32768), 8'(v), 1'b1, {8'(v * 3 + 1), 8'(v)});
    end

    // R5: low half of memory is not video
    run_fetch(16'h1234, 8'h12, 1'b1, 16'hA500);
    // R6: plain read of a video address
    run_fetch(16'hC001, 8'h05, 1'b0, 16'hA500);
    // forced fetch after the ignored ones still works
    run_fetch(16'hC002, 8'h81, 1'b1, 16'hFE00);

    // R9: row sweep with wrap
    vsync = 1'b1; idle(2); vsync = 1'b0; idle(1); exp_row = '0;
    check("R10 clear", line_row, 3'd0);
    for (int k = 0; k < 10; k++) begin
      hpulse();
      check("R9 step", line_row, exp_row);
    end
    // R10: simultaneous hsync edge and vsync
    hsync = 1'b1; vsync = 1'b1; idle(1);
    check("R10 collision", line_row, 3'd0);
    hsync = 1'b0; vsync = 1'b0; idle(1);
    exp_row = '0;
    hpulse();
    check("R9 after clear", line_row, 3'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule